// File: doc/BRIEF.md
# Interrupt Entry Arbiter and Vector Sequencer

This block sits next to an instruction execution unit. It gathers every reason the processor may have to enter an interrupt handler: internal exceptions and software interrupt instructions, the overflow-conditional interrupt instruction, a non-maskable request pin, a maskable request pin and the single-step trap. At each instruction boundary it picks at most one winner by fixed priority. A winner's type number selects its handler.

Once a winner is accepted, the block walks a fixed entry sequence, one step per clock. If the winner is a maskable request, it first runs an acknowledge cycle that reads an 8-bit type from the bus. It then requests three stack pushes (flags, code segment, instruction pointer), pulses strobes that clear the interrupt-enable and trap flags, and issues two reads of the vector table in the low 1 KB of memory. A one-cycle done pulse ends the sequence. The stack itself, the bus transfers and the return from the handler are handled by the surrounding logic.

Top module: `intv_ctrl`

## Requirements
- R1: After reset the block is idle. No push, vector read, acknowledge or done is driven, and `vec_addr_o` reads 0xFFFF0.
- R2: When several sources request at one boundary, the winner is chosen in this order: explicit exception/software request, then overflow-conditional request, then pending NMI, then enabled maskable request, then single-step.
- R3: An exception/software request enters with the 8-bit type on `soft_type_i`. Any of the 256 values is accepted, including 0 (divide error), 3 (breakpoint), 6 (unused opcode) and 7 (escape opcode). The overflow-conditional request enters with type 4, and is ignored unless `of_i` is 1.
- R4: A rising edge on `nmi_i` is latched and held until a boundary serves it with type 2. The latch then clears, so an idle boundary afterwards starts no entry.
- R5: The maskable request is taken only when `if_i` is 1. It drives `inta_o` until `ack_valid_i` is seen, and enters with the type on `ack_type_i`. When `if_i` is 0 it is ignored.
- R6: When `tf_i` is 1 and no other source wins, the entry uses type 1.
- R7: An entry makes exactly three pushes on consecutive cycles, with `push_sel_o` equal to 0 (flags), then 1 (code segment), then 2 (instruction pointer). `clr_if_o` and `clr_tf_o` pulse together in the flags-push cycle.
- R8: After the pushes, the block makes two vector reads on consecutive cycles. The first has `vec_half_o`=0 at address type×4 (offset word). The second has `vec_half_o`=1 at address type×4+2 (segment word). Both addresses lie below 0x400.
- R9: Requests are sampled only when the block is idle and `boundary_i` is 1. The entry ends with a one-cycle `done_o`, while `type_o` shows the serviced type, and the block is idle on the next cycle.
- R10: At most one of push, vector read, acknowledge and done is active in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| boundary_i | input | 1 | Instruction boundary strobe |
| soft_req_i | input | 1 | Exception or software interrupt request |
| soft_type_i | input | 8 | Type for soft_req_i |
| into_req_i | input | 1 | Overflow-conditional interrupt request |
| of_i | input | 1 | Overflow flag |
| nmi_i | input | 1 | Non-maskable request (edge sensitive) |
| intr_i | input | 1 | Maskable request (level) |
| if_i | input | 1 | Interrupt-enable flag |
| tf_i | input | 1 | Trap (single-step) flag |
| ack_valid_i | input | 1 | Type byte valid during acknowledge |
| ack_type_i | input | 8 | Type byte read during acknowledge |
| busy_o | output | 1 | Entry sequence in progress |
| inta_o | output | 1 | Acknowledge cycle active |
| push_o | output | 1 | Stack push request |
| push_sel_o | output | 2 | Pushed item: 0 flags, 1 code segment, 2 instruction pointer |
| clr_if_o | output | 1 | Clear interrupt-enable flag strobe |
| clr_tf_o | output | 1 | Clear trap flag strobe |
| vec_rd_o | output | 1 | Vector table read request |
| vec_half_o | output | 1 | 0 offset word, 1 segment word |
| vec_addr_o | output | 20 | Vector read address |
| done_o | output | 1 | Entry complete pulse |
| type_o | output | 8 | Type of the current entry |

## Verification
The arbitration is driven with directed stacks of simultaneous requests, each built so that exactly one priority level separates the expected winner from the runner-up. Gated cases use a request with its enable flag cleared (maskable with IF low, overflow-conditional with OF low), and the test expects no entry at all. This separates a gate that was dropped from a wrong priority. An NMI pulse that loses to an exception is checked again at a later, otherwise empty boundary, which tells a held latch from a lost edge or one that never clears. Random mixes of all sources, including random acknowledge bytes and types up to 0xFF, check the push order, the strobes and both vector addresses of every entry against a model of the priority rules.

// File: rtl/intv_pkg.sv
package intv_pkg;

    localparam int TYPE_W = 8;
    localparam int VLO_W  = TYPE_W + 2;

    localparam logic [TYPE_W-1:0] T_STEP = 8'd1;
    localparam logic [TYPE_W-1:0] T_NMI  = 8'd2;
    localparam logic [TYPE_W-1:0] T_OVF  = 8'd4;

    typedef enum logic [2:0] {
        ST_IDLE, ST_ACK, ST_PFL, ST_PCS, ST_PIP, ST_VOFF, ST_VSEG, ST_DONE
    } seq_st_e;

    typedef enum logic [1:0] {
        PS_FLAGS = 2'd0,
        PS_CS    = 2'd1,
        PS_IP    = 2'd2
    } push_sel_e;

    typedef enum logic [2:0] {
        SRC_NONE, SRC_SOFT, SRC_OVF, SRC_NMI, SRC_INTR, SRC_STEP
    } src_e;

    typedef struct packed {
        logic              valid;
        src_e              src;
        logic [TYPE_W-1:0] vtype;
        logic              need_ack;
    } pick_t;

    // Low part of a vector table address: type*4, plus 2 for the segment word
    function automatic logic [VLO_W-1:0] vec_lo(input logic [TYPE_W-1:0] t,
                                                input logic seg);
        return {t, seg, 1'b0};
    endfunction

endpackage

// File: rtl/intv_nmi_latch.sv
module intv_nmi_latch (
    input  logic clk,
    input  logic rst,
    input  logic nmi_i,
    input  logic take_i,
    output logic pend_o
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
            pend_o <= 1'b0;
        end else begin
            prev_q <= nmi_i;
            // a new edge wins over a clear in the same cycle
            pend_o <= (pend_o & ~take_i) | (nmi_i & ~prev_q);
        end
    end
endmodule

// File: rtl/intv_arbiter.sv
module intv_arbiter
    import intv_pkg::*;
(
    input  logic              soft_req_i,
    input  logic [TYPE_W-1:0] soft_type_i,
    input  logic              into_req_i,
    input  logic              of_i,
    input  logic              nmi_pend_i,
    input  logic              intr_i,
    input  logic              if_i,
    input  logic              tf_i,
    output pick_t             pick_o
);
    always_comb begin
        pick_o = '{valid: 1'b0, src: SRC_NONE, vtype: '0, need_ack: 1'b0};
        if (soft_req_i)
            pick_o = '{valid: 1'b1, src: SRC_SOFT, vtype: soft_type_i, need_ack: 1'b0};
        else if (into_req_i && of_i)
            pick_o = '{valid: 1'b1, src: SRC_OVF, vtype: T_OVF, need_ack: 1'b0};
        else if (nmi_pend_i)
            pick_o = '{valid: 1'b1, src: SRC_NMI, vtype: T_NMI, need_ack: 1'b0};
        else if (intr_i && if_i)
            pick_o = '{valid: 1'b1, src: SRC_INTR, vtype: '0, need_ack: 1'b1};
        else if (tf_i)
            pick_o = '{valid: 1'b1, src: SRC_STEP, vtype: T_STEP, need_ack: 1'b0};
    end
endmodule

// File: rtl/intv_seq.sv
module intv_seq
    import intv_pkg::*;
#(
    parameter int              ADDR_W     = 20,
    parameter logic [ADDR_W-1:0] RESET_ADDR = 20'hFFFF0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              boundary_i,
    input  pick_t             pick_i,
    input  logic              ack_valid_i,
    input  logic [TYPE_W-1:0] ack_type_i,
    output seq_st_e           st_o,
    output logic              take_nmi_o,
    output logic [TYPE_W-1:0] type_o,
    output logic [ADDR_W-1:0] addr_o
);
    localparam int PAD_W = ADDR_W - VLO_W;

    logic accept;
    assign accept     = (st_o == ST_IDLE) && boundary_i && pick_i.valid;
    assign take_nmi_o = accept && (pick_i.src == SRC_NMI);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_o   <= ST_IDLE;
            type_o <= '0;
            addr_o <= RESET_ADDR;
        end else begin
            unique case (st_o)
                ST_IDLE: if (accept) begin
                    type_o <= pick_i.vtype;
                    st_o   <= pick_i.need_ack ? ST_ACK : ST_PFL;
                end
                ST_ACK: if (ack_valid_i) begin
                    type_o <= ack_type_i;
                    st_o   <= ST_PFL;
                end
                ST_PFL:  st_o <= ST_PCS;
                ST_PCS:  st_o <= ST_PIP;
                ST_PIP: begin
                    addr_o <= {{PAD_W{1'b0}}, vec_lo(type_o, 1'b0)};
                    st_o   <= ST_VOFF;
                end
                ST_VOFF: begin
                    addr_o <= {{PAD_W{1'b0}}, vec_lo(type_o, 1'b1)};
                    st_o   <= ST_VSEG;
                end
                ST_VSEG: st_o <= ST_DONE;
                ST_DONE: st_o <= ST_IDLE;
                default: st_o <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/intv_ctrl.sv
module intv_ctrl
    import intv_pkg::*;
#(
    parameter int              ADDR_W     = 20,
    parameter logic [ADDR_W-1:0] RESET_ADDR = 20'hFFFF0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              boundary_i,
    input  logic              soft_req_i,
    input  logic [7:0]        soft_type_i,
    input  logic              into_req_i,
    input  logic              of_i,
    input  logic              nmi_i,
    input  logic              intr_i,
    input  logic              if_i,
    input  logic              tf_i,
    input  logic              ack_valid_i,
    input  logic [7:0]        ack_type_i,
    output logic              busy_o,
    output logic              inta_o,
    output logic              push_o,
    output logic [1:0]        push_sel_o,
    output logic              clr_if_o,
    output logic              clr_tf_o,
    output logic              vec_rd_o,
    output logic              vec_half_o,
    output logic [ADDR_W-1:0] vec_addr_o,
    output logic              done_o,
    output logic [7:0]        type_o
);
    logic    nmi_pend, take_nmi;
    pick_t   pick;
    seq_st_e st;

    intv_nmi_latch u_nmi (
        .clk(clk), .rst(rst), .nmi_i(nmi_i), .take_i(take_nmi), .pend_o(nmi_pend)
    );

    intv_arbiter u_arb (
        .soft_req_i(soft_req_i), .soft_type_i(soft_type_i),
        .into_req_i(into_req_i), .of_i(of_i), .nmi_pend_i(nmi_pend),
        .intr_i(intr_i), .if_i(if_i), .tf_i(tf_i), .pick_o(pick)
    );

    intv_seq #(.ADDR_W(ADDR_W), .RESET_ADDR(RESET_ADDR)) u_seq (
        .clk(clk), .rst(rst), .boundary_i(boundary_i), .pick_i(pick),
        .ack_valid_i(ack_valid_i), .ack_type_i(ack_type_i),
        .st_o(st), .take_nmi_o(take_nmi), .type_o(type_o), .addr_o(vec_addr_o)
    );

    always_comb begin
        busy_o     = (st != ST_IDLE);
        inta_o     = (st == ST_ACK);
        push_o     = (st == ST_PFL) || (st == ST_PCS) || (st == ST_PIP);
        push_sel_o = (st == ST_PCS) ? PS_CS : (st == ST_PIP) ? PS_IP : PS_FLAGS;
        clr_if_o   = (st == ST_PFL);
        clr_tf_o   = (st == ST_PFL);
        vec_rd_o   = (st == ST_VOFF) || (st == ST_VSEG);
        vec_half_o = (st == ST_VSEG);
        done_o     = (st == ST_DONE);
    end
endmodule

// File: rtl/intv_ctrl_chk.sv
module intv_ctrl_chk #(
    parameter int              ADDR_W     = 20,
    parameter logic [ADDR_W-1:0] RESET_ADDR = 20'hFFFF0
) (
    input logic              clk,
    input logic              rst,
    input logic              busy_o,
    input logic              inta_o,
    input logic              push_o,
    input logic [1:0]        push_sel_o,
    input logic              clr_if_o,
    input logic              clr_tf_o,
    input logic              vec_rd_o,
    input logic              vec_half_o,
    input logic [ADDR_W-1:0] vec_addr_o,
    input logic              done_o
);
    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!busy_o && vec_addr_o == RESET_ADDR)); // R1
    AST_ONE_ACTION: assert property (@(posedge clk) disable iff (rst)
        $onehot0({push_o, vec_rd_o, inta_o, done_o})); // R10
    AST_CLR_ON_FLAGS: assert property (@(posedge clk) disable iff (rst)
        (clr_if_o || clr_tf_o) |-> (clr_if_o && clr_tf_o && push_o && push_sel_o == 2'd0)); // R7
    AST_CS_AFTER_FLAGS: assert property (@(posedge clk) disable iff (rst)
        (push_o && push_sel_o == 2'd1) |-> $past(push_o && push_sel_o == 2'd0)); // R7
    AST_IP_AFTER_CS: assert property (@(posedge clk) disable iff (rst)
        (push_o && push_sel_o == 2'd2) |-> $past(push_o && push_sel_o == 2'd1)); // R7
    AST_VOFF_AFTER_IP: assert property (@(posedge clk) disable iff (rst)
        (vec_rd_o && !vec_half_o) |-> $past(push_o && push_sel_o == 2'd2)); // R8
    AST_VSEG_PLUS2: assert property (@(posedge clk) disable iff (rst)
        (vec_rd_o && vec_half_o) |-> ($past(vec_rd_o && !vec_half_o) &&
                                      vec_addr_o == $past(vec_addr_o) + 2)); // R8
    AST_VEC_LOW_KB: assert property (@(posedge clk) disable iff (rst)
        vec_rd_o |-> (vec_addr_o < 'h400)); // R8
    AST_DONE_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !busy_o); // R9
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> (!push_o && !vec_rd_o && !inta_o && !done_o)); // R9
endmodule

bind intv_ctrl intv_ctrl_chk #(.ADDR_W(ADDR_W), .RESET_ADDR(RESET_ADDR)) u_chk (
    .clk(clk), .rst(rst), .busy_o(busy_o), .inta_o(inta_o), .push_o(push_o),
    .push_sel_o(push_sel_o), .clr_if_o(clr_if_o), .clr_tf_o(clr_tf_o),
    .vec_rd_o(vec_rd_o), .vec_half_o(vec_half_o), .vec_addr_o(vec_addr_o),
    .done_o(done_o)
);

// File: tb/intv_ctrl_tb.sv
module intv_ctrl_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic boundary_i = 0, soft_req_i = 0, into_req_i = 0, of_i = 0;
    logic nmi_i = 0, intr_i = 0, if_i = 0, tf_i = 0, ack_valid_i = 0;
    logic [7:0] soft_type_i = 0, ack_type_i = 0;
    logic busy_o, inta_o, push_o, clr_if_o, clr_tf_o, vec_rd_o, vec_half_o, done_o;
    logic [1:0]  push_sel_o;
    logic [19:0] vec_addr_o;
    logic [7:0]  type_o;

    int n_cmp = 0, n_bad = 0;
    bit nmi_model = 0;

    always #10 clk = ~clk;

    intv_ctrl u_dut (.*);

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // expected winner type, -1 when no entry; R2 priority order
    function automatic int exp_type(bit sr, bit [7:0] st, bit ov, bit of, bit np,
                                    bit ir, bit ie, bit tf, bit [7:0] ak,
                                    output bit is_nmi, output bit is_intr);
        is_nmi = 0; is_intr = 0;
        if (sr) return int'(st);
        if (ov && of) return 4;
        if (np) begin is_nmi = 1; return 2; end
        if (ir && ie) begin is_intr = 1; return int'(ak); end
        if (tf) return 1;
        return -1;
    endfunction

    task automatic scenario(input bit sr, input bit [7:0] st, input bit ov, input bit of,
                            input bit np, input bit ir, input bit ie, input bit tf,
                            input bit [7:0] ak, input string tag);
        int e;
        bit is_nmi, is_intr, saw_ack, got_done;
        int pushes;
        if (np) begin
            @(negedge clk); nmi_i = 1;
            @(negedge clk); nmi_i = 0; nmi_model = 1;
        end else @(negedge clk);
        soft_req_i = sr; soft_type_i = st; into_req_i = ov; of_i = of;
        intr_i = ir; if_i = ie; tf_i = tf; boundary_i = 1;
        e = exp_type(sr, st, ov, of, nmi_model, ir, ie, tf, ak, is_nmi, is_intr);
        @(negedge clk);
        boundary_i = 0; soft_req_i = 0; into_req_i = 0; intr_i = 0; tf_i = 0; of_i = 0;
        if (e < 0) begin
            chk(busy_o == 0 && push_o == 0, {tag, " no entry expected"}, busy_o, 0);
            return;
        end
        if (is_nmi) nmi_model = 0;
        pushes = 0; saw_ack = 0; got_done = 0;
        for (int c = 0; c < 20 && !got_done; c++) begin
            if (inta_o) begin saw_ack = 1; ack_valid_i = 1; ack_type_i = ak; end
            else ack_valid_i = 0;
            if (push_o) begin
                chk(push_sel_o == 2'(pushes), "R7 push order", push_sel_o, pushes);
                if (pushes == 0)
                    chk(clr_if_o && clr_tf_o, "R7 flag clears with flags push",
                        {clr_if_o, clr_tf_o}, 2'b11);
                pushes++;
            end
            if (vec_rd_o)
                chk(vec_addr_o == 20'(e * 4 + (vec_half_o ? 2 : 0)), "R8 vector address",
                    vec_addr_o, e * 4 + (vec_half_o ? 2 : 0));
            if (done_o) begin
                got_done = 1;
                chk(type_o == 8'(e), {tag, " serviced type"}, type_o, e);
            end
            @(negedge clk);
        end
        ack_valid_i = 0;
        chk(got_done, "R9 done reached", got_done, 1);
        chk(pushes == 3, "R7 three pushes", pushes, 3);
        chk(saw_ack == is_intr, "R5 acknowledge only for maskable", saw_ack, is_intr);
        chk(busy_o == 0, "R9 idle after done", busy_o, 0);
    endtask

    initial begin
        #(20 * 150000);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(!busy_o && !push_o && !inta_o && !vec_rd_o && !done_o, "R1 reset idle",
            busy_o, 0);
        chk(vec_addr_o == 20'hFFFF0, "R1 reset address", vec_addr_o, 20'hFFFF0);

        // R2/R3: exception beats everything; NMI left pending
        scenario(1, 8'd0, 1, 1, 1, 1, 1, 1, 8'h33, "R2 exception first");
        // R4: latched NMI served later, then cleared
        scenario(0, 0, 0, 0, 0, 0, 0, 0, 8'h00, "R4 held NMI");
        scenario(0, 0, 0, 0, 0, 0, 0, 0, 8'h00, "R4 NMI cleared");
        // R5: masked and enabled maskable
        scenario(0, 0, 0, 0, 0, 1, 0, 0, 8'h47, "R5 masked INTR");
        scenario(0, 0, 0, 0, 0, 1, 1, 0, 8'h47, "R5 enabled INTR");
        // R3: overflow-conditional gating
        scenario(0, 0, 1, 0, 0, 0, 0, 0, 8'h00, "R3 INTO without OF");
        scenario(0, 0, 1, 1, 0, 0, 0, 0, 8'h00, "R3 INTO with OF");
        // R6 and R2 ordering among lower levels
        scenario(0, 0, 0, 0, 0, 0, 0, 1, 8'h00, "R6 single-step");
        scenario(0, 0, 0, 0, 0, 1, 1, 1, 8'h9A, "R2 INTR over step");
        scenario(0, 0, 0, 0, 1, 1, 1, 1, 8'h9A, "R2 NMI over INTR");
        scenario(0, 0, 1, 1, 1, 0, 0, 0, 8'h00, "R2 INTO over NMI");
        scenario(0, 0, 0, 0, 0, 0, 0, 0, 8'h00, "R4 NMI after INTO");
        // R3 fixed exception types and the top of the table (R8)
        scenario(1, 8'd3, 0, 0, 0, 0, 0, 0, 8'h00, "R3 breakpoint");
        scenario(1, 8'd6, 0, 0, 0, 0, 0, 0, 8'h00, "R3 unused opcode");
        scenario(1, 8'd7, 0, 0, 0, 0, 0, 0, 8'h00, "R3 escape opcode");
        scenario(1, 8'hFF, 0, 0, 0, 0, 0, 0, 8'h00, "R3 type 255");

        for (int i = 0; i < 200; i++) begin
            scenario(($urandom % 5) == 0, 8'($urandom), $urandom % 2, $urandom % 2,
                     ($urandom % 4) == 0, $urandom % 2, $urandom % 2, $urandom % 2,
                     8'($urandom), "R2 random mix");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule